// File: doc/BRIEF.md
# BCD calendar real-time clock

This block keeps wall-clock time and a calendar as packed BCD bytes (tens digit in the high nibble, units digit in the low nibble) in 24-hour form. A host reads and writes the time fields, three spare storage bytes and two control/status registers over a simple single-cycle bus with an 8-bit address and 8-bit data. Reads return data in the cycle after the read strobe.

Time is derived from a 32.768 kHz tick-enable input. A three-state divider machine makes the one-second events. `DIV_HALT` holds the prescaler cleared while the divider code is a stop code. `DIV_WARMUP` is entered on release (`HALT -> WARMUP`) and fires the first second after half a second of enables (`WARMUP -> RUN`). `DIV_RUN` fires a second every full second of enables. Any stop code returns both active states to `DIV_HALT` (`WARMUP -> HALT`, `RUN -> HALT`). The reset state is `DIV_WARMUP`. A freeze bit holds the calendar while the divider keeps counting. A separate divide-by-32 of the same enable produces a 1024 Hz periodic interrupt pulse under its own enable bit. The update-in-progress flag flips on every read of the control register, so polling software never waits on it for long.

Top module: `rtc_bcd_top`

## Requirements
- R1: Seconds (0x00), minutes (0x02) and hours (0x04) are packed BCD. Each one-second event adds one second, with seconds and minutes wrapping 59 to 00 and hours wrapping 23 to 00, each wrap carrying into the next field.
- R2: On a day carry, day of week (0x06, range 1..7) wraps 7 to 1. Day of month (0x07) wraps to 01 after 31, 30, 28 or 29 days by month (0x08, 1..12), with February given 29 days when the two-digit year (0x09) is a multiple of 4. Month wraps 12 to 01 and carries into the year, and the year wraps 99 to 00.
- R3: Register A (0x0A) holds the update flag in bit 7, the divider code in bits 6:4 and the rate field in bits 3:0. Divider codes 110 and 111 stop time and discard any partly counted second. Every other code runs.
- R4: After the divider leaves a stop code, the first second event comes after HALF_COUNT enables and each later one after FULL_COUNT enables.
- R5: While bit 7 (freeze) of register B (0x0B) is 1, second events leave every time field unchanged.
- R6: A write to register A keeps bit 7 at its previous value.
- R7: Each read of register A inverts bit 7 and returns the inverted value.
- R8: While bit 6 of register B is 1, `periodic_irq` pulses for one cycle every IRQ_DIV enables. Clearing the bit stops the pulses and clears the count, so that after re-enabling, the first pulse comes after a full IRQ_DIV enables.
- R9: After reset, A holds 0x26 (update flag clear), B holds 0x42, and the time reads 00:00:00 on day of week 07, date 01, month 01, year 00.
- R10: Reads of 0x0C, 0x0D and addresses from 0x0E upward return 0x00, and writes to them have no effect.
- R11: Addresses 0x01, 0x03 and 0x05 are plain storage bytes, and each read returns its data one cycle after the strobe.
- R12: A host write to a time field in the same cycle as a calendar step takes priority for that field, while carries into the other fields still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| periodic_irq | output | 1 | One-cycle periodic interrupt pulse |

## Verification
On every cycle, the bound checker checks the following: the update flag holding across register A writes, the flag flipping on register A reads, the seconds byte staying still while frozen, no second event while a stop code is set, a silent interrupt while it is disabled, and zero data from the upper status registers. Only the bench scenarios can show the calendar carries, including leap February and the century wrap, and the half-second first tick after release. The same applies to the discarded partial second, the priority of a colliding write, and the interrupt count restarting after re-enable. These are compared against a bench calendar model over directed edge dates and random dates.

// File: rtl/rtc_bcd_pkg.sv
`timescale 1ns/1ps
package rtc_bcd_pkg;

    typedef enum logic [1:0] {
        DIV_HALT   = 2'd0,
        DIV_WARMUP = 2'd1,
        DIV_RUN    = 2'd2
    } div_state_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] dom;
        logic [7:0] mon;
        logic [7:0] year;
    } cal_t;

    localparam logic [7:0] A_SEC   = 8'h00;
    localparam logic [7:0] A_MIN   = 8'h02;
    localparam logic [7:0] A_HOUR  = 8'h04;
    localparam logic [7:0] A_DOW   = 8'h06;
    localparam logic [7:0] A_DOM   = 8'h07;
    localparam logic [7:0] A_MON   = 8'h08;
    localparam logic [7:0] A_YEAR  = 8'h09;
    localparam logic [7:0] A_CTLA  = 8'h0A;
    localparam logic [7:0] A_CTLB  = 8'h0B;

    localparam logic [2:0] DV_RUN_CODE = 3'b010;
    localparam logic [3:0] RS_1024     = 4'b0110;
    localparam logic [7:0] CTLB_RESET  = 8'h42;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic year_is_leap(input logic [7:0] y);
        if (!y[4])
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_divider.sv
`timescale 1ns/1ps
module rtc_divider
    import rtc_bcd_pkg::*;
#(
    parameter int HALF_COUNT = 16384,
    parameter int FULL_COUNT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic tick_32k,
    output logic sec_tick
);
    localparam int CW = $clog2(FULL_COUNT);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF_COUNT - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(FULL_COUNT - 1);

    div_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_HALT:   if (run_en) state_d = DIV_WARMUP;
            DIV_WARMUP: begin
                if (!run_en)
                    state_d = DIV_HALT;
                else if (tick_32k && cnt_q == HALF_LAST)
                    state_d = DIV_RUN;
            end
            DIV_RUN:    if (!run_en) state_d = DIV_HALT;
            default:    state_d = DIV_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DIV_WARMUP;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= 1'b0;
            unique case (state_q)
                DIV_HALT: cnt_q <= '0;
                DIV_WARMUP: begin
                    if (!run_en) cnt_q <= '0;
                    else if (tick_32k) begin
                        if (cnt_q == HALF_LAST) begin
                            cnt_q    <= '0;
                            sec_tick <= 1'b1;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                end
                DIV_RUN: begin
                    if (!run_en) cnt_q <= '0;
                    else if (tick_32k) begin
                        if (cnt_q == FULL_LAST) begin
                            cnt_q    <= '0;
                            sec_tick <= 1'b1;
                        end else cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_periodic.sv
`timescale 1ns/1ps
module rtc_periodic #(
    parameter int IRQ_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic tick_32k,
    output logic irq_pulse
);
    localparam int PW = (IRQ_DIV > 1) ? $clog2(IRQ_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(IRQ_DIV - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !irq_en) begin
            cnt_q     <= '0;
            irq_pulse <= 1'b0;
        end else if (tick_32k && cnt_q == LAST) begin
            cnt_q     <= '0;
            irq_pulse <= 1'b1;
        end else begin
            cnt_q     <= tick_32k ? cnt_q + 1'b1 : cnt_q;
            irq_pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
    import rtc_bcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    output cal_t       cal
);
    cal_t adv, nxt;
    logic c_min, c_hour, c_day, c_mon, c_year;

    always_comb begin
        adv    = cal;
        c_min  = step && cal.sec == 8'h59;
        c_hour = c_min && cal.min == 8'h59;
        c_day  = c_hour && cal.hour == 8'h23;
        c_mon  = c_day && cal.dom == month_last(cal.mon, cal.year);
        c_year = c_mon && cal.mon == 8'h12;
        if (step)   adv.sec  = c_min  ? 8'h00 : bcd_inc(cal.sec);
        if (c_min)  adv.min  = c_hour ? 8'h00 : bcd_inc(cal.min);
        if (c_hour) adv.hour = c_day  ? 8'h00 : bcd_inc(cal.hour);
        if (c_day) begin
            adv.dow = (cal.dow == 8'h07) ? 8'h01 : cal.dow + 8'h01;
            adv.dom = c_mon ? 8'h01 : bcd_inc(cal.dom);
        end
        if (c_mon)  adv.mon  = c_year ? 8'h01 : bcd_inc(cal.mon);
        if (c_year) adv.year = (cal.year == 8'h99) ? 8'h00 : bcd_inc(cal.year);
    end

    always_comb begin
        nxt = adv;
        if (wr_en) begin
            case (wr_addr)
                A_SEC:   nxt.sec  = wr_data;
                A_MIN:   nxt.min  = wr_data;
                A_HOUR:  nxt.hour = wr_data;
                A_DOW:   nxt.dow  = wr_data;
                A_DOM:   nxt.dom  = wr_data;
                A_MON:   nxt.mon  = wr_data;
                A_YEAR:  nxt.year = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cal <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h07,
                             dom: 8'h01, mon: 8'h01, year: 8'h00};
        else        cal <= nxt;
    end
endmodule

// File: rtl/rtc_bcd_top.sv
`timescale 1ns/1ps
module rtc_bcd_top
    import rtc_bcd_pkg::*;
#(
    parameter int HALF_COUNT = 16384,
    parameter int FULL_COUNT = 32768,
    parameter int IRQ_DIV    = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       periodic_irq
);
    localparam int NSPARE = 3;

    logic       uip_q;
    logic [2:0] dv_q;
    logic [3:0] rs_q;
    logic [7:0] regb_q;
    logic [7:0] spare_q [NSPARE];
    logic       run_en, sec_tick, step;
    logic [7:0] rd_val;
    cal_t       cal;

    assign run_en = (dv_q[2:1] != 2'b11);
    assign step   = sec_tick && !regb_q[7];

    rtc_divider #(.HALF_COUNT(HALF_COUNT), .FULL_COUNT(FULL_COUNT)) div_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick_32k(tick_32k), .sec_tick(sec_tick));

    rtc_periodic #(.IRQ_DIV(IRQ_DIV)) per_i (
        .clk(clk), .rst_n(rst_n), .irq_en(regb_q[6]), .tick_32k(tick_32k),
        .irq_pulse(periodic_irq));

    rtc_calendar cal_i (
        .clk(clk), .rst_n(rst_n), .step(step), .wr_en(bus_wr), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .cal(cal));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uip_q  <= 1'b0;
            dv_q   <= DV_RUN_CODE;
            rs_q   <= RS_1024;
            regb_q <= CTLB_RESET;
        end else begin
            if (bus_wr && bus_addr == A_CTLA) begin
                dv_q <= bus_wdata[6:4];
                rs_q <= bus_wdata[3:0];
            end
            if (bus_rd && bus_addr == A_CTLA) uip_q <= ~uip_q;
            if (bus_wr && bus_addr == A_CTLB) regb_q <= bus_wdata;
        end
    end

    for (genvar g = 0; g < NSPARE; g++) begin : g_spare
        localparam logic [7:0] SPARE_ADDR = 8'(2 * g + 1);
        always_ff @(posedge clk) begin
            if (!rst_n)                                spare_q[g] <= 8'h00;
            else if (bus_wr && bus_addr == SPARE_ADDR) spare_q[g] <= bus_wdata;
        end
    end

    always_comb begin
        case (bus_addr)
            A_SEC:   rd_val = cal.sec;
            A_MIN:   rd_val = cal.min;
            A_HOUR:  rd_val = cal.hour;
            A_DOW:   rd_val = cal.dow;
            A_DOM:   rd_val = cal.dom;
            A_MON:   rd_val = cal.mon;
            A_YEAR:  rd_val = cal.year;
            8'h01:   rd_val = spare_q[0];
            8'h03:   rd_val = spare_q[1];
            8'h05:   rd_val = spare_q[2];
            A_CTLA:  rd_val = {~uip_q, dv_q, rs_q};
            A_CTLB:  rd_val = regb_q;
            default: rd_val = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= 8'h00;
        else if (bus_rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/rtc_bcd_chk.sv
`timescale 1ns/1ps
module rtc_bcd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       uip,
    input logic [2:0] dv,
    input logic       sec_tick,
    input logic       freeze,
    input logic       irq_en,
    input logic       irq,
    input logic [7:0] sec_val
);
    assert_uip_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == 8'h0A) |=> uip == $past(uip));

    assert_uip_read_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'h0A) |=> uip != $past(uip));

    assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !(bus_wr && bus_addr == 8'h00)) |=> $stable(sec_val));

    assert_halt_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dv[2:1] == 2'b11) |=> !sec_tick);

    assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == 8'h0C || bus_addr == 8'h0D)) |=> bus_rdata == 8'h00);
endmodule

bind rtc_bcd_top rtc_bcd_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .uip(uip_q), .dv(dv_q), .sec_tick(sec_tick),
    .freeze(regb_q[7]), .irq_en(regb_q[6]), .irq(periodic_irq), .sec_val(cal.sec));

// File: tb/rtc_bcd_top_tb_top.sv
`timescale 1ns/1ps
module rtc_bcd_top_tb_top;
    localparam int HALF = 8;
    localparam int FULL = 16;
    localparam int IRQD = 4;

    logic clk = 1'b0, rst_n = 1'b0, tick_32k = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic periodic_irq;

    int tests = 0, fails = 0, irq_seen = 0;
    bit done = 0, exp_uip = 0;
    int e [7];

    always #2 clk = ~clk;

    rtc_bcd_top #(.HALF_COUNT(HALF), .FULL_COUNT(FULL), .IRQ_DIV(IRQD)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .periodic_irq(periodic_irq));

    always @(negedge clk) if (rst_n && periodic_irq) irq_seen++;

    function automatic int to_bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic logic [7:0] fld_addr(int i);
        case (i)
            0: return 8'h00; 1: return 8'h02; 2: return 8'h04; 3: return 8'h06;
            4: return 8'h07; 5: return 8'h08; default: return 8'h09;
        endcase
    endfunction

    function automatic int days_in(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        e[0]++;
        if (e[0] == 60) begin
            e[0] = 0; e[1]++;
            if (e[1] == 60) begin
                e[1] = 0; e[2]++;
                if (e[2] == 24) begin
                    e[2] = 0;
                    e[3] = (e[3] == 7) ? 1 : e[3] + 1;
                    if (e[4] == days_in(e[5], e[6])) begin
                        e[4] = 1;
                        if (e[5] == 12) begin e[5] = 1; e[6] = (e[6] + 1) % 100; end
                        else e[5]++;
                    end else e[4]++;
                end
            end
        end
    endtask

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic ticks(int n);
        if (n > 0) begin
            @(negedge clk); tick_32k = 1'b1;
            repeat (n) @(negedge clk);
            tick_32k = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_time(string req);
        logic [7:0] v;
        for (int i = 0; i < 7; i++) begin
            rd(fld_addr(i), v);
            chk(req, v, to_bcd(e[i]));
        end
    endtask

    task automatic set_time(int s, int mi, int h, int dw, int d, int mo, int y);
        e[0] = s; e[1] = mi; e[2] = h; e[3] = dw; e[4] = d; e[5] = mo; e[6] = y;
        wr(8'h0A, 8'h66);
        for (int i = 0; i < 7; i++) wr(fld_addr(i), 8'(to_bcd(e[i])));
        wr(8'h0A, 8'h26);
    endtask

    task automatic run_case(string req, int s, int mi, int h, int dw, int d, int mo, int y, int k);
        set_time(s, mi, h, dw, d, mo, y);
        ticks(HALF + k * FULL);
        for (int j = 0; j <= k; j++) model_step();
        check_time(req);
    endtask

    task automatic read_ctla(string req);
        logic [7:0] v;
        exp_uip = ~exp_uip;
        rd(8'h0A, v);
        chk(req, v[7], exp_uip);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int base, s0;
        void'($urandom(32'd20240229));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset values
        rd(8'h0A, v); exp_uip = 1'b1; chk("R9", v, 8'hA6);
        rd(8'h0B, v); chk("R9", v, 8'h42);
        e = '{0, 0, 0, 7, 1, 1, 0};
        check_time("R9");

        // R10 upper registers and unmapped space
        rd(8'h0C, v); chk("R10", v, 0);
        rd(8'h0D, v); chk("R10", v, 0);
        wr(8'h0C, 8'hFF); rd(8'h0C, v); chk("R10", v, 0);
        wr(8'h40, 8'h5A); rd(8'h40, v); chk("R10", v, 0);

        // R11 storage bytes
        wr(8'h01, 8'h5A); wr(8'h03, 8'hC3); wr(8'h05, 8'h17);
        rd(8'h01, v); chk("R11", v, 8'h5A);
        rd(8'h03, v); chk("R11", v, 8'hC3);
        rd(8'h05, v); chk("R11", v, 8'h17);

        // R6 write keeps update flag, R7 reads flip it
        wr(8'h0A, exp_uip ? 8'h26 : 8'hA6);
        read_ctla("R6");
        read_ctla("R7");
        read_ctla("R7");

        // R1 and R2 directed rollovers
        run_case("R1", 58, 59, 13, 2, 10, 6, 77, 1);
        run_case("R2", 59, 59, 23, 7, 28, 2, 24, 0);
        run_case("R2", 59, 59, 23, 3, 28, 2, 23, 0);
        run_case("R2", 59, 59, 23, 1, 29, 2, 0, 0);
        run_case("R2", 59, 59, 23, 4, 30, 4, 50, 0);
        run_case("R2", 59, 59, 23, 5, 31, 12, 99, 0);

        // R4 first tick after half, then every full
        set_time(10, 0, 0, 1, 1, 1, 10);
        ticks(HALF - 1); rd(8'h00, v); chk("R4", v, 8'h10);
        ticks(1);        rd(8'h00, v); chk("R4", v, 8'h11);
        ticks(FULL - 1); rd(8'h00, v); chk("R4", v, 8'h11);
        ticks(1);        rd(8'h00, v); chk("R4", v, 8'h12);

        // R3 stop codes halt time and discard a partial second
        wr(8'h0A, 8'h76); ticks(3 * FULL); rd(8'h00, v); chk("R3", v, 8'h12);
        wr(8'h0A, 8'h26); ticks(HALF - 1);
        wr(8'h0A, 8'h66); wr(8'h0A, 8'h26); ticks(HALF - 1);
        rd(8'h00, v); chk("R3", v, 8'h12);
        ticks(1); rd(8'h00, v); chk("R3", v, 8'h13);

        // R5 freeze bit holds time while the divider runs
        set_time(30, 5, 5, 1, 1, 1, 10);
        wr(8'h0B, 8'hC2);
        ticks(HALF + 2 * FULL); rd(8'h00, v); chk("R5", v, 8'h30);
        wr(8'h0B, 8'h42);
        ticks(FULL); rd(8'h00, v); chk("R5", v, 8'h31);

        // R12 write colliding with a calendar step
        set_time(59, 10, 1, 1, 1, 1, 10);
        @(negedge clk); tick_32k = 1'b1;
        repeat (HALF) @(negedge clk);
        tick_32k = 1'b0; bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 8'h33;
        @(negedge clk); bus_wr = 1'b0;
        repeat (2) @(negedge clk);
        rd(8'h00, v); chk("R12", v, 8'h33);
        rd(8'h02, v); chk("R12", v, 8'h11);

        // R8 periodic interrupt
        wr(8'h0B, 8'h02); base = irq_seen;
        ticks(5 * IRQD); chk("R8", irq_seen - base, 0);
        wr(8'h0B, 8'h42); base = irq_seen;
        ticks(IRQD - 1); chk("R8", irq_seen - base, 0);
        wr(8'h0B, 8'h02); wr(8'h0B, 8'h42); base = irq_seen;
        ticks(IRQD - 1); chk("R8", irq_seen - base, 0);
        ticks(1);        chk("R8", irq_seen - base, 1);
        ticks(2 * IRQD); chk("R8", irq_seen - base, 3);

        // R1/R2 random dates, biased toward field ends
        for (int it = 0; it < 30; it++) begin
            int yy, mm, dd;
            bit edge_c;
            edge_c = $urandom_range(1, 0) == 1;
            yy = $urandom_range(99, 0);
            mm = $urandom_range(12, 1);
            dd = edge_c ? days_in(mm, yy) : $urandom_range(days_in(mm, yy), 1);
            s0 = edge_c ? 59 - $urandom_range(1, 0) : $urandom_range(59, 0);
            run_case("R2", s0, edge_c ? 59 : $urandom_range(59, 0),
                     edge_c ? 23 : $urandom_range(23, 0), $urandom_range(7, 1),
                     dd, mm, yy, $urandom_range(2, 0));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule